// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

A synchronous up counter, four bits wide by default, that steps through the full binary range and returns to zero after the all-ones state. Its state can be cleared or preset from a parallel data bus. Two separate enables control counting: a parallel enable and a trickle enable. Only the trickle enable takes part in the terminal-count output, and that is what lets several stages be chained. In a chain, each stage's terminal count drives the trickle enable of the next stage, and the parallel enables of all stages are tied together, so the chain counts as one wider binary counter.

A build-time parameter selects how the active-low clear works. In the first form it acts at once, without waiting for the clock. In the second form it takes effect on the next rising edge. Every other state change happens on the rising clock edge. The counter's state is undefined at power-up until the first clear or load.

Top module: `presettable_counter`

## Requirements
- R1: When counting, the all-ones state (15 at the default width) is followed by zero on the next counting edge.
- R2: With `ASYNC_CLR`=1, a low `clr_n` forces `q` to zero at once, without a clock edge, whatever the other inputs are.
- R3: With `ASYNC_CLR`=0, a low `clr_n` leaves `q` unchanged until the next rising edge, and `q` is zero after that edge. On that edge the clear takes priority over load and count.
- R4: With `clr_n` high and `load_n` low, a rising edge copies `din` into `q`, whatever the values of `en_p` and `en_t`.
- R5: With `clr_n` and `load_n` both high, and `en_p` and `en_t` both high, a rising edge increments `q` by one.
- R6: With `clr_n` and `load_n` both high, a low on either `en_p` or `en_t` keeps `q` unchanged across the edge.
- R7: `tc` is high exactly when `q` is all ones and `en_t` is high. `en_p` has no effect on `tc`.
- R8: A loaded value is used unchanged as the next count origin, and counting continues from it. Loading all ones while `en_t` is high raises `tc` in the same cycle the value appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; acts at once or on the next edge, depending on `ASYNC_CLR` |
| load_n | input | 1 | Active-low parallel preset |
| en_p | input | 1 | Parallel count enable |
| en_t | input | 1 | Trickle count enable; also gates `tc` |
| din | input | WIDTH | Preset data |
| q | output | WIDTH | Counter state |
| tc | output | 1 | Terminal count, used to chain stages |

## Verification
The bench builds two copies of the counter at the default width: one with `ASYNC_CLR`=1 and one with `ASYNC_CLR`=0. Both copies receive the same stimulus. Because both forms behave the same at clock edges, a single reference model covers both, and the edge-based checks cover every combination of the four control inputs from several preset states. The only place the two forms differ is between edges. Dropping the clear in the middle of a cycle shows that difference directly: one copy goes to zero at once while the other keeps its value.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  typedef enum logic [1:0] {M_HOLD, M_COUNT, M_LOAD, M_CLEAR} mode_e;

  // Fixed precedence: clear, then preset, then count, then hold.
  function automatic mode_e pick_mode(input logic clr_n, input logic load_n,
                                      input logic en_p, input logic en_t);
    if (!clr_n)             return M_CLEAR;
    else if (!load_n)       return M_LOAD;
    else if (en_p && en_t)  return M_COUNT;
    else                    return M_HOLD;
  endfunction
endpackage

// File: rtl/pcnt_mode_dec.sv
module pcnt_mode_dec
  import pcnt_pkg::*;
(
  input  logic  clr_n,
  input  logic  load_n,
  input  logic  en_p,
  input  logic  en_t,
  output mode_e mode
);
  always_comb mode = pick_mode(clr_n, load_n, en_p, en_t);
endmodule

// File: rtl/pcnt_next.sv
module pcnt_next
  import pcnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  mode_e             mode,
  input  logic [WIDTH-1:0]  cur,
  input  logic [WIDTH-1:0]  din,
  output logic [WIDTH-1:0]  nxt
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  // Modulo 2**WIDTH step: the carry out of the top bit is dropped.
  function automatic logic [WIDTH-1:0] step(input logic [WIDTH-1:0] v);
    return v + ONE;
  endfunction

  always_comb begin
    unique case (mode)
      M_CLEAR: nxt = '0;
      M_LOAD:  nxt = din;
      M_COUNT: nxt = step(cur);
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/pcnt_reg.sv
module pcnt_reg #(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic [WIDTH-1:0]  nxt,
  output logic [WIDTH-1:0]  q
);
  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= nxt;
      end
    end else begin : g_sync
      // In this form the clear reaches the register through nxt.
      always_ff @(posedge clk) q <= nxt;
    end
  endgenerate
endmodule

// File: rtl/pcnt_term.sv
module pcnt_term #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             en_t,
  output logic             tc
);
  function automatic logic at_top(input logic [WIDTH-1:0] v);
    return &v;
  endfunction

  assign tc = at_top(q) & en_t;
endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
  import pcnt_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             en_p,
  input  logic             en_t,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             tc
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  mode_e            mode;
  logic [WIDTH-1:0] nxt;

  // Named events for the checks below.
  logic do_clear, do_load, do_count, do_hold;
  assign do_clear = (mode == M_CLEAR);
  assign do_load  = (mode == M_LOAD);
  assign do_count = (mode == M_COUNT);
  assign do_hold  = (mode == M_HOLD);

  pcnt_mode_dec u_dec (
    .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t), .mode(mode)
  );

  pcnt_next #(.WIDTH(WIDTH)) u_next (
    .mode(mode), .cur(q), .din(din), .nxt(nxt)
  );

  pcnt_reg #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_reg (
    .clk(clk), .clr_n(clr_n), .nxt(nxt), .q(q)
  );

  pcnt_term #(.WIDTH(WIDTH)) u_term (
    .q(q), .en_t(en_t), .tc(tc)
  );

  // ---------------- assertions ----------------
  // State is undefined until the first clear or load has been clocked in.
  logic armed = 1'b0;
  always_ff @(posedge clk) if (do_clear || do_load) armed <= 1'b1;

  logic [WIDTH-1:0] q_plus;
  assign q_plus = q + ONE;

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!armed || !clr_n)
    do_count |=> q == $past(q_plus));

  // R1
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!armed || !clr_n)
    (do_count && q == TOP) |=> q == '0);

  // R4
  load_take_chk: assert property (@(posedge clk) disable iff (!armed || !clr_n)
    do_load |=> q == $past(din));

  // R6
  hold_keep_chk: assert property (@(posedge clk) disable iff (!armed || !clr_n)
    do_hold |=> $stable(q));

  // R7
  tc_match_chk: assert property (@(posedge clk) disable iff (!armed)
    tc == ((q == TOP) && en_t));

  generate
    if (ASYNC_CLR) begin : g_async_chk
      // R2
      async_zero_chk: assert property (@(posedge clk) disable iff (!armed)
        !clr_n |-> q == '0);
    end else begin : g_sync_chk
      // R3
      sync_zero_chk: assert property (@(posedge clk) disable iff (!armed)
        do_clear |=> q == '0);
    end
  endgenerate
endmodule

// File: tb/presettable_counter_bench.sv
`timescale 1ns/100ps
module presettable_counter_bench;
  logic       clk = 1'b0;
  logic       clr_n = 1'b0, load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
  logic [3:0] din = 4'h0;
  logic [3:0] qa, qs;
  logic       tca, tcs;

  always #2.5 clk = ~clk;   // 200 MHz

  presettable_counter #(.WIDTH(4), .ASYNC_CLR(1'b1)) u_presettable_counter (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .din(din), .q(qa), .tc(tca));

  presettable_counter #(.WIDTH(4), .ASYNC_CLR(1'b0)) u_presettable_counter_sync (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .din(din), .q(qs), .tc(tcs));

  typedef struct {
    logic [3:0] q;
    logic       tc;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  logic [3:0] model = 4'h0;
  int         checks = 0;
  int         fails = 0;

  task automatic chk(input string tag, input string what, input logic [3:0] act,
                     input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Driver: applies one cycle of controls and queues the result expected after the edge.
  task automatic drive(input logic c, input logic l, input logic p, input logic t,
                       input logic [3:0] d, input string tag_in);
    exp_t  e;
    string tag;
    @(negedge clk);
    clr_n = c; load_n = l; en_p = p; en_t = t; din = d;
    if (!c)          begin tag = "R3"; model = 4'h0; end
    else if (!l)     begin tag = "R4"; model = d; end
    else if (p && t) begin tag = (model == 4'hF) ? "R1" : "R5"; model = model + 4'h1; end
    else             tag = "R6";
    if (tag_in != "") tag = tag_in;
    e.q = model;
    e.tc = (model == 4'hF) && t;
    e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compares both copies one step after each rising edge.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        chk(e.tag, "q async copy", qa, e.q);
        chk(e.tag, "q sync copy", qs, e.q);
        chk("R7", "tc async copy", {3'b0, tca}, {3'b0, e.tc});
        chk("R7", "tc sync copy", {3'b0, tcs}, {3'b0, e.tc});
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // Reset state: clear first, since the power-up state is undefined.
    drive(1'b0, 1'b1, 1'b0, 1'b0, 4'h0, "R3");
    drive(1'b1, 1'b1, 1'b1, 1'b1, 4'h0, "");

    // Free run through the wrap (R1, R5).
    for (int i = 0; i < 20; i++) drive(1'b1, 1'b1, 1'b1, 1'b1, 4'h3, "");

    // Every control combination from several preset states.
    foreach (sb[i]) ;
    for (int s = 0; s < 4; s++) begin
      logic [3:0] st;
      st = (s == 0) ? 4'h0 : (s == 1) ? 4'h7 : (s == 2) ? 4'hE : 4'hF;
      for (int c = 0; c < 16; c++) begin
        drive(1'b1, 1'b0, 1'b0, 1'b0, st, "");
        drive(c[3], c[2], c[1], c[0], 4'hA, "");
      end
    end

    // R8: load all ones with the trickle enable high, then keep counting.
    drive(1'b1, 1'b0, 1'b0, 1'b1, 4'hF, "R8");
    drive(1'b1, 1'b1, 1'b1, 1'b1, 4'h0, "R8");
    drive(1'b1, 1'b0, 1'b1, 1'b1, 4'h9, "R8");
    drive(1'b1, 1'b1, 1'b1, 1'b1, 4'h0, "R8");
    drive(1'b1, 1'b1, 1'b1, 1'b1, 4'h0, "R8");
    // R7: the parallel enable does not affect tc.
    drive(1'b1, 1'b0, 1'b0, 1'b1, 4'hF, "R7");
    drive(1'b1, 1'b1, 1'b0, 1'b1, 4'h0, "R7");
    drive(1'b1, 1'b1, 1'b1, 1'b0, 4'h0, "R7");

    // Mid-cycle clear: the async copy drops at once, the sync copy waits (R2, R3).
    drive(1'b1, 1'b0, 1'b0, 1'b0, 4'h6, "R4");
    @(posedge clk);
    #1;
    @(negedge clk);
    clr_n = 1'b0; load_n = 1'b1;
    #1;
    chk("R2", "q async copy before edge", qa, 4'h0);
    chk("R3", "q sync copy before edge", qs, 4'h6);
    @(posedge clk);
    #1;
    chk("R3", "q sync copy after edge", qs, 4'h0);
    model = 4'h0;
    drive(1'b1, 1'b1, 1'b1, 1'b1, 4'h0, "");

    repeat (3) @(posedge clk);
    #2;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule